// File: doc/BRIEF.md
# Conditional Trap Condition Evaluator

This block decides whether a conditional trap instruction fires. It takes two 64-bit operands, the 32-bit instruction word and a flag that selects 32-bit or 64-bit operand width. It also takes a 5-bit vector of trap causes that are already pending. The block compares the two operands as signed numbers and as unsigned numbers at the same time. It then keeps only the comparison results that the instruction selects through its 5-bit option field. The trap request is raised when any selected result is true or when any pending cause is set.

The block has no registers. An execution stage places it between operand read and the exception logic: it reads `trap_hit` in the same cycle and also records `cmp_vec` for debug. The block does not decode the instruction beyond the option field, does not update any machine state, and has no handshake.

Top module: `trap_condition_eval`

## Requirements
- R1: The option mask is bits 25 down to 21 of `insn_word` (bit 0 is the LSB). Word bit 25 gates `cmp_vec[4]` and word bit 21 gates `cmp_vec[0]`, in positional order.
- R2: `cmp_vec` bit 0 = unsigned A>B, bit 1 = unsigned A<B, bit 2 = A==B, bit 3 = signed A>B, bit 4 = signed A<B. Exactly one of bits 0..2 is set at any time.
- R3: With `word_mode`=1, the signed comparisons (bits 3 and 4) use bits 31:0 of each operand, sign-extended to 64 bits. Bits 63:32 have no effect.
- R4: With `word_mode`=1, the unsigned comparisons and the equality test (bits 0..2) use bits 31:0 of each operand, zero-extended. Bits 63:32 have no effect.
- R5: With `word_mode`=0, all five comparisons use the full 64-bit operands.
- R6: When any bit of `pend_type` is set, `trap_hit` is 1, whatever the operands and the mask are.
- R7: `trap_hit` = OR-reduction of (`cmp_vec` AND mask) OR OR-reduction of `pend_type`.
- R8: When the mask is zero and `pend_type` is zero, `trap_hit` is 0 for any operands.
- R9: Equality is a single result shared by both orderings. Exactly one of bits 2, 3 and 4 is set, and bit 2 is set exactly when the extended signed operands are equal.
- R10: The bits of `insn_word` outside 25:21 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Trap instruction word; the option mask sits in bits 25:21 |
| opnd_a | input | 64 | First operand (A) |
| opnd_b | input | 64 | Second operand (B) |
| word_mode | input | 1 | 1 = compare the low 32 bits, 0 = compare all 64 bits |
| pend_type | input | 5 | Pending trap causes; any set bit forces a trap |
| cmp_vec | output | 5 | Raw comparison results, exposed for debug |
| trap_hit | output | 1 | Take-trap decision |

## Verification
Two functions can act in the same evaluation: a forced trap from a pending cause, and a trap from a masked comparison. The bench sets both together by driving non-zero `pend_type` with masks that select true results, that select false results, and that select nothing. It expects `trap_hit` to be the OR of the two sources and `cmp_vec` to stay unchanged by the pending causes. The signed and unsigned paths also meet on the shared equality result. Operand pairs whose low words are equal but whose high words differ are evaluated in both width modes, and the bench checks that the unsigned and signed orderings give one consistent three-way answer.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;

    localparam int CMP_W = 5;

    // Bit order of the comparison vector is behavioural: the option mask
    // gates it position by position.
    typedef struct packed {
        logic slt;  // bit 4
        logic sgt;  // bit 3
        logic eq;   // bit 2
        logic ult;  // bit 1
        logic ugt;  // bit 0
    } cmp_vec_t;

endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [1:0][DATA_W-1:0] raw_i,
    input  logic                   word_mode_i,
    output logic [1:0][DATA_W-1:0] sgn_o,
    output logic [1:0][DATA_W-1:0] uns_o
);
    localparam int PAD_W = DATA_W - HALF_W;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        always_comb begin
            if (word_mode_i) begin
                sgn_o[g] = {{PAD_W{raw_i[g][HALF_W-1]}}, raw_i[g][HALF_W-1:0]};
                uns_o[g] = {{PAD_W{1'b0}}, raw_i[g][HALF_W-1:0]};
            end else begin
                sgn_o[g] = raw_i[g];
                uns_o[g] = raw_i[g];
            end
        end
    end

endmodule

// File: rtl/trap_compare_core.sv
module trap_compare_core
    import trap_eval_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] sgn_a_i,
    input  logic [DATA_W-1:0] sgn_b_i,
    input  logic [DATA_W-1:0] uns_a_i,
    input  logic [DATA_W-1:0] uns_b_i,
    output cmp_vec_t          vec_o
);
    always_comb begin
        vec_o.ugt = uns_a_i > uns_b_i;
        vec_o.ult = uns_a_i < uns_b_i;
        vec_o.eq  = uns_a_i == uns_b_i;
        vec_o.sgt = $signed(sgn_a_i) > $signed(sgn_b_i);
        vec_o.slt = $signed(sgn_a_i) < $signed(sgn_b_i);
    end

    always_comb begin
        p_uns_trichotomy_r2: assert ($countones({vec_o.ugt, vec_o.ult, vec_o.eq}) == 1)
            else $error("unsigned ordering not one-hot");
        p_sgn_trichotomy_r9: assert ($countones({vec_o.sgt, vec_o.slt, vec_o.eq}) == 1)
            else $error("signed ordering not one-hot");
        p_eq_agree_r9: assert ((sgn_a_i == sgn_b_i) == vec_o.eq)
            else $error("equality differs between signed and unsigned views");
    end

endmodule

// File: rtl/trap_decide.sv
module trap_decide #(
    parameter int CMP_W  = 5,
    parameter int TYPE_W = 5
) (
    input  logic [CMP_W-1:0]  vec_i,
    input  logic [CMP_W-1:0]  mask_i,
    input  logic [TYPE_W-1:0] pend_i,
    output logic              hit_o
);
    logic [CMP_W-1:0] sel;

    always_comb begin
        sel   = vec_i & mask_i;
        hit_o = (|sel) | (|pend_i);
    end

endmodule

// File: rtl/trap_condition_eval.sv
module trap_condition_eval
    import trap_eval_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int HALF_W     = 32,
    parameter int INSN_W     = 32,
    parameter int MASK_FIRST = 6,
    parameter int TYPE_W     = 5
) (
    input  logic [INSN_W-1:0] insn_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              word_mode,
    input  logic [TYPE_W-1:0] pend_type,
    output logic [CMP_W-1:0]  cmp_vec,
    output logic              trap_hit
);
    // Mask field is numbered from the MSB of the instruction word.
    localparam int MASK_HI = INSN_W - 1 - MASK_FIRST;
    localparam int MASK_LO = MASK_HI - CMP_W + 1;

    typedef struct packed {
        logic [CMP_W-1:0] mask;
        cmp_vec_t         vec;
        logic             hit;
    } eval_t;

    eval_t                   eval_d;
    logic [1:0][DATA_W-1:0]  raw;
    logic [1:0][DATA_W-1:0]  sgn;
    logic [1:0][DATA_W-1:0]  uns;
    cmp_vec_t                vec_w;
    logic                    hit_w;

    assign raw[0] = opnd_a;
    assign raw[1] = opnd_b;

    trap_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
        .raw_i       (raw),
        .word_mode_i (word_mode),
        .sgn_o       (sgn),
        .uns_o       (uns)
    );

    trap_compare_core #(.DATA_W(DATA_W)) u_cmp (
        .sgn_a_i (sgn[0]),
        .sgn_b_i (sgn[1]),
        .uns_a_i (uns[0]),
        .uns_b_i (uns[1]),
        .vec_o   (vec_w)
    );

    trap_decide #(.CMP_W(CMP_W), .TYPE_W(TYPE_W)) u_decide (
        .vec_i  (vec_w),
        .mask_i (eval_d.mask),
        .pend_i (pend_type),
        .hit_o  (hit_w)
    );

    always_comb begin
        eval_d      = '0;
        eval_d.mask = insn_word[MASK_HI:MASK_LO];
        eval_d.vec  = vec_w;
        eval_d.hit  = hit_w;
    end

    assign cmp_vec  = eval_d.vec;
    assign trap_hit = eval_d.hit;

    always_comb begin
        if (pend_type != '0) begin
            p_pend_forces_r6: assert (trap_hit)
                else $error("pending cause did not force a trap");
        end
        if ((insn_word[MASK_HI:MASK_LO] == '0) && (pend_type == '0)) begin
            p_no_cause_r8: assert (!trap_hit)
                else $error("trap raised with no cause");
        end
        if (word_mode) begin
            p_eq_low_r4: assert (cmp_vec[2] == (opnd_a[HALF_W-1:0] == opnd_b[HALF_W-1:0]))
                else $error("narrow equality wrong");
            if (opnd_a[HALF_W-1] == opnd_b[HALF_W-1]) begin
                p_sign_agree_r3: assert (cmp_vec[4] == cmp_vec[1])
                    else $error("same-sign narrow operands order differently");
            end
        end else begin
            p_eq_full_r5: assert (cmp_vec[2] == (opnd_a == opnd_b))
                else $error("wide equality wrong");
        end
    end

endmodule

// File: tb/trap_condition_eval_test.sv
module trap_condition_eval_test;

    typedef struct {
        logic [4:0] vec;
        logic       hit;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn_word = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        word_mode = 1'b0;
    logic [4:0]  pend_type = '0;
    logic [4:0]  cmp_vec;
    logic        trap_hit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    trap_condition_eval uut (
        .insn_word (insn_word),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .word_mode (word_mode),
        .pend_type (pend_type),
        .cmp_vec   (cmp_vec),
        .trap_hit  (trap_hit)
    );

    function automatic logic [63:0] corner(input int k);
        case (k)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h1234_5678_0000_0005;
            5: return 64'hABCD_EF00_0000_0005;
            6: return 64'h0000_0000_7FFF_FFFF;
            default: return 64'h7FFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Independent model: bit0 ugt, bit1 ult, bit2 eq, bit3 sgt, bit4 slt.
    function automatic logic [4:0] model_vec(input logic [63:0] a, input logic [63:0] b,
                                             input logic wm);
        longint          sa, sb_;
        longint unsigned ua, ub;
        if (wm) begin
            sa = longint'(int'(a[31:0]));
            sb_ = longint'(int'(b[31:0]));
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end else begin
            sa = a; sb_ = b; ua = a; ub = b;
        end
        return {sa < sb_, sa > sb_, ua == ub, ua < ub, ua > ub};
    endfunction

    task automatic drive(input logic [31:0] iw, input logic [63:0] a, input logic [63:0] b,
                         input logic wm, input logic [4:0] pt, input string tag);
        exp_t e;
        logic [4:0] m;
        @(posedge clk);
        insn_word = iw; opnd_a = a; opnd_b = b; word_mode = wm; pend_type = pt;
        m = iw[25:21];
        e.vec = model_vec(a, b, wm);
        e.hit = ((e.vec & m) != 0) || (pt != 0);
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (cmp_vec !== e.vec) begin
                errors++;
                $display("FAIL %s cmp_vec actual %b expected %b", e.tag, cmp_vec, e.vec);
            end
            checks++;
            if (trap_hit !== e.hit) begin
                errors++;
                $display("FAIL %s trap_hit actual %b expected %b", e.tag, trap_hit, e.hit);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs: operands equal, nothing selected (R2, R8)
        drive(32'h0, 64'h0, 64'h0, 1'b0, 5'h0, "R2/R8 idle");
        // R10: every bit outside the mask field set, mask zero
        drive(32'hFC1F_FFFF, 64'h5, 64'h3, 1'b0, 5'h0, "R10 stray bits");
        drive(32'hFC1F_FFFF, 64'h3, 64'h5, 1'b1, 5'h0, "R10 stray bits");
        // R1: one mask bit at a time against A>B unsigned (only bit 0 true)
        for (int k = 0; k < 5; k++)
            drive(32'h1 << (21 + k), 64'h9, 64'h2, 1'b0, 5'h0, "R1 single mask bit");
        // Exhaustive corner sweep (R2 R3 R4 R5 R7 R9), random stray insn bits (R10)
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
                for (int wm = 0; wm < 2; wm++)
                    for (int m = 0; m < 32; m++) begin
                        logic [31:0] iw;
                        iw = ($urandom() & 32'hFC1F_FFFF) | (32'(m) << 21);
                        drive(iw, corner(ia), corner(ib), wm[0], 5'h0,
                              wm ? "R3/R4/R7/R9/R10 narrow" : "R5/R7/R9/R10 wide");
                    end
        // R8: zero mask, zero causes, all corners
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
                drive(32'h0, corner(ia), corner(ib), ia[0], 5'h0, "R8 no cause");
        // R6: pending causes combined with selecting and non-selecting masks
        for (int p = 1; p < 32; p++)
            for (int m = 0; m < 32; m += 7)
                drive(32'(m) << 21, corner(p % 8), corner((p * 3) % 8), p[1], 5'(p),
                      "R6/R7 pending");
        drive(32'h0, 64'h0, 64'h0, 1'b0, 5'h0, "R2 final");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule